// File: doc/BRIEF.md
# Tagged-Status Serial Receiver

This block turns a single serial input line into characters. It handles two kinds of framing. In the first, the line is free-running: bit timing comes from a baud tick that is oversampled sixteen times per bit. In the second, the line is clocked: an external sample clock marks each bit on the edge the user selects. A frame starts with a low start bit and carries 5 to 9 data bits, least significant bit first. An optional parity bit may follow the data, and the frame ends with a stop bit. The receiver only examines the first stop bit. Any further stop time is treated as an idle line.

Each finished character goes into a two-slot receive queue. The framing error, parity error and overrun flags are stored in the same slot as the character they describe, and so is the ninth data bit. The read side always shows the oldest slot. A pulse on the read strobe for the low data byte removes that slot. Software must therefore read the ninth bit and the flags before it takes the data. Dropping the enable abandons any frame in progress and empties the queue.

Top module: `serial_rx_tagq`

## Requirements
- R1: After reset, and whenever the queue is empty, rd_valid, rd_data, rd_bit8, rd_ferr, rd_perr and rd_ovr are all 0.
- R2: In free-running mode, a low line seen on a baud tick is only a candidate start bit. It is confirmed by a sample on the 8th following tick. If that sample is high, the receiver returns to idle and stores nothing.
- R3: In free-running mode, every later bit is sampled once per 16 baud ticks, and only cycles with baud_tick=1 advance the timing. Data bits arrive least significant bit first.
- R4: With sync_mode=1, bits are sampled on the selected edge of sclk: the rising edge when sclk_fall_sel=0, the falling edge when sclk_fall_sel=1. A low sample at such an edge while idle is a start bit.
- R5: char_size codes 3'b000, 3'b001, 3'b010 and 3'b011 give 5, 6, 7 and 8 data bits. Code 3'b111 gives 9 data bits, and the ninth bit is shown on rd_bit8. Codes 3'b100 to 3'b110 give 8 bits. Bit positions above the frame size read 0.
- R6: With par_en=1, a parity bit follows the last data bit. For even parity (par_odd=0) the data bits plus the parity bit must hold an even count of ones; for odd parity (par_odd=1) the count must be odd. A mismatch sets rd_perr for that character.
- R7: The first stop bit is sampled. If it is low, the character is still stored, with rd_ferr=1. A second stop bit is not checked.
- R8: Characters leave the queue oldest first. A cycle with rd_pop=1 while rd_valid=1 removes the oldest slot.
- R9: The ninth bit and the flags stay attached to their own character. The head slot shows them unchanged until that slot is popped.
- R10: If a frame completes while both slots are full and no pop happens in that cycle, the new frame is dropped. rd_ovr is set on the newest stored slot, and the older slot is left unchanged.
- R11: With rx_en=0, the queue is emptied, any frame in progress is abandoned, and the line is ignored.
- R12: A pop while the queue is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable; low aborts the current frame and empties the queue |
| sync_mode | input | 1 | 0 = free-running with 16x baud tick, 1 = sampled on the external clock |
| sclk_fall_sel | input | 1 | Selects the sampling edge of sclk: 0 rising, 1 falling |
| baud_tick | input | 1 | One-cycle oversampling tick (16 per bit) |
| sclk | input | 1 | External sample clock for clocked framing |
| rxd | input | 1 | Serial data line, idles high |
| char_size | input | 3 | Data-bit count code |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rd_pop | input | 1 | Read strobe for the low data byte; removes the head slot |
| rd_valid | output | 1 | Queue holds at least one character |
| rd_data | output | 8 | Low eight data bits of the head slot |
| rd_bit8 | output | 1 | Ninth data bit of the head slot |
| rd_ferr | output | 1 | Framing error flag of the head slot |
| rd_perr | output | 1 | Parity error flag of the head slot |
| rd_ovr | output | 1 | Overrun flag of the head slot |

## Verification
The receiver is given free-running frames at every frame size, including the nine-bit size and a reserved code. These show whether bits are placed least significant bit first and whether the upper bits are masked. Each parity sense is sent once with a correct parity bit and once with a flipped one; parity errors must be flagged only where the bit was flipped. Other stimulus covers a stop bit held low, a short low pulse that must be rejected as a glitch, and clocked framing on each sclk edge. Three characters are sent without reading, which separates a correct overrun (third frame dropped, flag on the second slot) from a design that overwrites. Further runs empty the queue with the enable, abort a frame halfway, and pop an empty queue.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int MAX_BITS = 9;
    localparam logic [2:0] SIZE_NINE = 3'b111;

    typedef struct packed {
        logic [MAX_BITS-1:0] data;
        logic                ferr;
        logic                perr;
        logic                ovr;
    } rx_entry_t;

    typedef enum logic [2:0] {
        FR_IDLE,
        FR_START,
        FR_DATA,
        FR_PARITY,
        FR_STOP
    } fr_state_e;

    // data bit count for a character-size code
    function automatic logic [3:0] frame_bits(input logic [2:0] code);
        logic [3:0] n;
        case (code)
            3'b000:  n = 4'd5;
            3'b001:  n = 4'd6;
            3'b010:  n = 4'd7;
            3'b011:  n = 4'd8;
            3'b111:  n = 4'd9;
            default: n = 4'd8;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/srx_line_sync.sv
module srx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd,
    input  logic sclk,
    output logic rx_s,
    output logic sclk_rise,
    output logic sclk_fall
);

    typedef struct packed {
        logic [STAGES-1:0] rxp;
        logic [STAGES-1:0] ckp;
        logic              ck_last;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d         = sync_q;
        sync_d.rxp     = {sync_q.rxp[STAGES-2:0], rxd};
        sync_d.ckp     = {sync_q.ckp[STAGES-2:0], sclk};
        sync_d.ck_last = sync_q.ckp[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q.rxp     <= '1;
            sync_q.ckp     <= '0;
            sync_q.ck_last <= 1'b0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign rx_s      = sync_q.rxp[STAGES-1];
    assign sclk_rise = sync_q.ckp[STAGES-1] & ~sync_q.ck_last;
    assign sclk_fall = ~sync_q.ckp[STAGES-1] & sync_q.ck_last;

endmodule

// File: rtl/srx_framer.sv
module srx_framer
    import srx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       sync_mode,
    input  logic       tick,
    input  logic       sedge,
    input  logic       rx_s,
    input  logic [2:0] char_size,
    input  logic       par_en,
    input  logic       par_odd,
    output logic       push,
    output rx_entry_t  entry
);

    localparam int CW = $clog2(OVERSAMPLE);
    localparam logic [CW-1:0] CNT_LAST = CW'(OVERSAMPLE - 1);
    localparam logic [CW-1:0] CNT_MID  = CW'(OVERSAMPLE / 2 - 1);

    typedef struct packed {
        fr_state_e           st;
        logic [CW-1:0]       cnt;
        logic [3:0]          idx;
        logic [MAX_BITS-1:0] data;
        logic                par;
        logic                perr;
    } fr_t;

    localparam fr_t FR_CLEAR = '{st: FR_IDLE, cnt: '0, idx: '0, data: '0,
                                 par: 1'b0, perr: 1'b0};

    fr_t fr_d, fr_q;
    logic [3:0] nbits;
    logic       last_bit;
    logic       bit_mid;
    logic       start_seen;

    always_comb begin
        fr_d       = fr_q;
        push       = 1'b0;
        entry      = '0;
        nbits      = frame_bits(char_size);
        last_bit   = (fr_q.idx == nbits - 4'd1);
        bit_mid    = sync_mode ? sedge : (tick && fr_q.cnt == CNT_LAST);
        start_seen = sync_mode ? (sedge && !rx_s) : (tick && !rx_s);

        if (!sync_mode && tick && fr_q.st != FR_IDLE && fr_q.st != FR_START) begin
            fr_d.cnt = (fr_q.cnt == CNT_LAST) ? '0 : fr_q.cnt + 1'b1;
        end

        case (fr_q.st)
            FR_IDLE: begin
                fr_d.cnt = '0;
                if (start_seen) begin
                    fr_d.idx  = '0;
                    fr_d.data = '0;
                    fr_d.par  = 1'b0;
                    fr_d.perr = 1'b0;
                    fr_d.st   = sync_mode ? FR_DATA : FR_START;
                end
            end
            FR_START: begin
                if (tick) begin
                    if (fr_q.cnt == CNT_MID) begin
                        fr_d.cnt = '0;
                        fr_d.st  = rx_s ? FR_IDLE : FR_DATA;
                    end else begin
                        fr_d.cnt = fr_q.cnt + 1'b1;
                    end
                end
            end
            FR_DATA: begin
                if (bit_mid) begin
                    fr_d.data[fr_q.idx] = rx_s;
                    fr_d.par            = fr_q.par ^ rx_s;
                    if (last_bit) begin
                        fr_d.st = par_en ? FR_PARITY : FR_STOP;
                    end else begin
                        fr_d.idx = fr_q.idx + 4'd1;
                    end
                end
            end
            FR_PARITY: begin
                if (bit_mid) begin
                    fr_d.perr = ((fr_q.par ^ rx_s) != par_odd);
                    fr_d.st   = FR_STOP;
                end
            end
            FR_STOP: begin
                if (bit_mid) begin
                    push       = 1'b1;
                    entry.data = fr_q.data;
                    entry.perr = fr_q.perr;
                    entry.ferr = ~rx_s;
                    entry.ovr  = 1'b0;
                    fr_d.st    = FR_IDLE;
                end
            end
            default: fr_d.st = FR_IDLE;
        endcase

        if (!en) begin
            fr_d = FR_CLEAR;
            push = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fr_q <= FR_CLEAR;
        else        fr_q <= fr_d;
    end

endmodule

// File: rtl/srx_tag_fifo.sv
module srx_tag_fifo
    import srx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  rx_entry_t                  push_entry,
    input  logic                       pop,
    output rx_entry_t                  head,
    output logic                       valid,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] level
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    typedef struct packed {
        rx_entry_t [DEPTH-1:0] slot;
        logic [PW-1:0]         wp;
        logic [PW-1:0]         rp;
        logic [LW-1:0]         cnt;
    } fifo_t;

    fifo_t ff_d, ff_q;
    logic  pop_ok;
    logic  push_ok;
    logic  full_now;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [PW-1:0] ptr_prev(input logic [PW-1:0] p);
        return (p == '0) ? PW'(DEPTH - 1) : p - 1'b1;
    endfunction

    always_comb begin
        ff_d     = ff_q;
        full_now = (ff_q.cnt == LW'(DEPTH));
        pop_ok   = pop && (ff_q.cnt != '0);
        push_ok  = push && !(full_now && !pop_ok);

        if (pop_ok) begin
            ff_d.rp = ptr_next(ff_q.rp);
        end

        if (push) begin
            if (push_ok) begin
                ff_d.slot[ff_q.wp] = push_entry;
                ff_d.wp            = ptr_next(ff_q.wp);
            end else begin
                ff_d.slot[ptr_prev(ff_q.wp)].ovr = 1'b1;
            end
        end

        ff_d.cnt = ff_q.cnt + LW'(push_ok) - LW'(pop_ok);

        if (flush) begin
            ff_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= '0;
        else        ff_q <= ff_d;
    end

    assign valid = (ff_q.cnt != '0);
    assign full  = (ff_q.cnt == LW'(DEPTH));
    assign level = ff_q.cnt;
    assign head  = valid ? ff_q.slot[ff_q.rp] : '0;

endmodule

// File: rtl/serial_rx_tagq.sv
module serial_rx_tagq
    import srx_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2,
    parameter int DEPTH       = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_en,
    input  logic       sync_mode,
    input  logic       sclk_fall_sel,
    input  logic       baud_tick,
    input  logic       sclk,
    input  logic       rxd,
    input  logic [2:0] char_size,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       rd_pop,
    output logic       rd_valid,
    output logic [7:0] rd_data,
    output logic       rd_bit8,
    output logic       rd_ferr,
    output logic       rd_perr,
    output logic       rd_ovr
);

    localparam int LW = $clog2(DEPTH + 1);

    logic          rx_s;
    logic          ck_rise;
    logic          ck_fall;
    logic          sedge;
    logic          frame_push;
    rx_entry_t     frame_entry;
    rx_entry_t     head;
    logic          fifo_full;
    logic [LW-1:0] fifo_level;

    srx_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .rxd       (rxd),
        .sclk      (sclk),
        .rx_s      (rx_s),
        .sclk_rise (ck_rise),
        .sclk_fall (ck_fall)
    );

    assign sedge = sclk_fall_sel ? ck_fall : ck_rise;

    srx_framer #(
        .OVERSAMPLE (OVERSAMPLE)
    ) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (rx_en),
        .sync_mode (sync_mode),
        .tick      (baud_tick),
        .sedge     (sedge),
        .rx_s      (rx_s),
        .char_size (char_size),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .push      (frame_push),
        .entry     (frame_entry)
    );

    srx_tag_fifo #(
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (~rx_en),
        .push       (frame_push),
        .push_entry (frame_entry),
        .pop        (rd_pop),
        .head       (head),
        .valid      (rd_valid),
        .full       (fifo_full),
        .level      (fifo_level)
    );

    assign rd_data = head.data[7:0];
    assign rd_bit8 = head.data[8];
    assign rd_ferr = head.ferr;
    assign rd_perr = head.perr;
    assign rd_ovr  = head.ovr;

endmodule

// File: rtl/srx_tagq_chk.sv
module srx_tagq_chk #(
    parameter int DEPTH = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       rx_en,
    input logic                       rd_pop,
    input logic                       rd_valid,
    input logic [7:0]                 rd_data,
    input logic                       rd_bit8,
    input logic                       rd_ferr,
    input logic                       rd_perr,
    input logic [2:0]                 char_size,
    input logic                       push,
    input logic                       push_bit8,
    input logic                       full,
    input logic [$clog2(DEPTH+1)-1:0] level
);

    // R11
    disable_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !rd_valid);

    // R12
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_valid && rd_pop && !push) |=> !rd_valid);

    // R9
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && rd_valid && !rd_pop) |=>
            (rd_valid && $stable({rd_data, rd_bit8, rd_ferr, rd_perr})));

    // R5
    ninth_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && char_size != 3'b111) |-> !push_bit8);

    // R10
    no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && push && full && !rd_pop) |=> (full && $stable(rd_data)));

    // R8
    pop_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && rd_valid && rd_pop && !push && level == 1) |=> !rd_valid);

endmodule

bind serial_rx_tagq srx_tagq_chk #(.DEPTH(DEPTH)) u_srx_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en     (rx_en),
    .rd_pop    (rd_pop),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .rd_bit8   (rd_bit8),
    .rd_ferr   (rd_ferr),
    .rd_perr   (rd_perr),
    .char_size (char_size),
    .push      (frame_push),
    .push_bit8 (frame_entry.data[8]),
    .full      (fifo_full),
    .level     (fifo_level)
);

// File: tb/tb_serial_rx_tagq.sv
module tb_serial_rx_tagq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0;
    logic       sync_mode = 1'b0;
    logic       sclk_fall_sel = 1'b0;
    logic       baud_tick = 1'b0;
    logic       sclk = 1'b0;
    logic       rxd = 1'b1;
    logic [2:0] char_size = 3'b011;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       rd_pop = 1'b0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       rd_bit8;
    logic       rd_ferr;
    logic       rd_perr;
    logic       rd_ovr;

    int    vectors = 0;
    int    miscompares = 0;
    string cur_req = "R1";
    bit    cmp_en = 1'b0;

    typedef struct {
        logic [8:0] d;
        logic       fe;
        logic       pe;
        logic       ov;
    } mexp_t;

    mexp_t mq[$];

    always #4 clk = ~clk;

    // baud tick on every other cycle
    always @(negedge clk) baud_tick <= ~baud_tick;

    serial_rx_tagq dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_en         (rx_en),
        .sync_mode     (sync_mode),
        .sclk_fall_sel (sclk_fall_sel),
        .baud_tick     (baud_tick),
        .sclk          (sclk),
        .rxd           (rxd),
        .char_size     (char_size),
        .par_en        (par_en),
        .par_odd       (par_odd),
        .rd_pop        (rd_pop),
        .rd_valid      (rd_valid),
        .rd_data       (rd_data),
        .rd_bit8       (rd_bit8),
        .rd_ferr       (rd_ferr),
        .rd_perr       (rd_perr),
        .rd_ovr        (rd_ovr)
    );

    function automatic int nbits_of(input logic [2:0] c);
        if (c == 3'b111) return 9;
        if (c < 3'b100)  return 5 + int'(c);
        return 8;
    endfunction

    task automatic compare_now(input string req);
        logic       ev;
        logic [8:0] ed;
        logic       efe, epe, eov;
        ev = (mq.size() > 0);
        ed = ev ? mq[0].d  : 9'd0;
        efe = ev ? mq[0].fe : 1'b0;
        epe = ev ? mq[0].pe : 1'b0;
        eov = ev ? mq[0].ov : 1'b0;
        vectors++;
        if ({rd_valid, rd_bit8, rd_data, rd_ferr, rd_perr, rd_ovr} !==
            {ev, ed, efe, epe, eov}) begin
            miscompares++;
            $display("FAIL %s: got v=%b d=%h fe=%b pe=%b ov=%b exp v=%b d=%h fe=%b pe=%b ov=%b",
                     req, rd_valid, {rd_bit8, rd_data}, rd_ferr, rd_perr, rd_ovr,
                     ev, ed, efe, epe, eov);
        end
    endtask

    // reference comparison on every clock, away from the edge
    always @(negedge clk) begin
        #1;
        if (cmp_en) compare_now(cur_req);
    end

    task automatic model_push(input logic [8:0] d, input logic fe, input logic pe);
        mexp_t e;
        e.d = d; e.fe = fe; e.pe = pe; e.ov = 1'b0;
        if (mq.size() >= 2) mq[mq.size()-1].ov = 1'b1;
        else                mq.push_back(e);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_async(input logic [8:0] d, input logic flip, input logic stop_bit);
        int         n;
        logic [8:0] m;
        logic       p;
        n = nbits_of(char_size);
        m = d & 9'((1 << n) - 1);
        p = (^m) ^ par_odd ^ flip;
        cmp_en = 1'b0;
        rxd = 1'b0; idle(32);
        for (int i = 0; i < n; i++) begin
            rxd = m[i]; idle(32);
        end
        if (par_en) begin
            rxd = p; idle(32);
        end
        rxd = stop_bit; idle(32);
        rxd = 1'b1;
        model_push(m, ~stop_bit, par_en & flip);
        cmp_en = 1'b1;
        idle(40);
    endtask

    task automatic send_sync(input logic [8:0] d, input logic flip);
        int         n;
        logic [8:0] m;
        logic       p;
        logic       bits[$];
        n = nbits_of(char_size);
        m = d & 9'((1 << n) - 1);
        p = (^m) ^ par_odd ^ flip;
        bits.push_back(1'b0);
        for (int i = 0; i < n; i++) bits.push_back(m[i]);
        if (par_en) bits.push_back(p);
        bits.push_back(1'b1);
        cmp_en = 1'b0;
        foreach (bits[i]) begin
            rxd = bits[i]; idle(4);
            sclk = ~sclk_fall_sel; idle(4);
            sclk = sclk_fall_sel;
        end
        idle(4);
        model_push(m, 1'b0, par_en & flip);
        cmp_en = 1'b1;
        idle(8);
    endtask

    task automatic do_pop();
        @(negedge clk) rd_pop = 1'b1;
        @(negedge clk) rd_pop = 1'b0;
        if (mq.size() > 0) mq.delete(0);
    endtask

    task automatic flush_all();
        cmp_en = 1'b0;
        rx_en = 1'b0;
        idle(2);
        mq.delete();
        cmp_en = 1'b1;
        idle(1);
        compare_now("R11");
        rx_en = 1'b1;
        idle(2);
    endtask

    initial begin
        rst_n = 1'b0;
        rx_en = 1'b1;
        idle(4);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        compare_now("R1");
        cmp_en = 1'b1;
        idle(10);

        // R3: 8-bit frames, LSB first, paced by baud ticks
        cur_req = "R3";
        char_size = 3'b011;
        send_async(9'h0A5, 1'b0, 1'b1);
        compare_now("R3");
        do_pop();
        send_async(9'h03C, 1'b0, 1'b1);
        do_pop();

        // R5: each frame size and reserved code
        cur_req = "R5";
        char_size = 3'b000; send_async(9'h1F5, 1'b0, 1'b1); compare_now("R5"); do_pop();
        char_size = 3'b001; send_async(9'h1EA, 1'b0, 1'b1); compare_now("R5"); do_pop();
        char_size = 3'b010; send_async(9'h1D3, 1'b0, 1'b1); compare_now("R5"); do_pop();
        char_size = 3'b111; send_async(9'h1A5, 1'b0, 1'b1); compare_now("R5"); do_pop();
        char_size = 3'b101; send_async(9'h1C6, 1'b0, 1'b1); compare_now("R5"); do_pop();
        char_size = 3'b011;

        // R6 and R9: parity errors stay with their own character
        cur_req = "R6";
        par_en = 1'b1; par_odd = 1'b0;
        send_async(9'h0B7, 1'b1, 1'b1);
        send_async(9'h0B7, 1'b0, 1'b1);
        compare_now("R6");
        cur_req = "R9";
        do_pop(); compare_now("R9");
        do_pop();
        cur_req = "R6";
        par_odd = 1'b1;
        send_async(9'h041, 1'b0, 1'b1); compare_now("R6"); do_pop();
        send_async(9'h041, 1'b1, 1'b1); compare_now("R6"); do_pop();
        char_size = 3'b111;
        send_async(9'h1FF, 1'b1, 1'b1); compare_now("R6"); do_pop();
        char_size = 3'b011;
        par_en = 1'b0; par_odd = 1'b0;

        // R7: low stop bit gives a framing error, second stop time unchecked
        cur_req = "R7";
        send_async(9'h066, 1'b0, 1'b0); compare_now("R7"); do_pop();
        send_async(9'h099, 1'b0, 1'b1); idle(32); compare_now("R7"); do_pop();

        // R2: short low pulse rejected
        cur_req = "R2";
        rxd = 1'b0; idle(6); rxd = 1'b1;
        idle(80);
        compare_now("R2");

        // R4: clocked framing on each edge
        cur_req = "R4";
        sync_mode = 1'b1;
        sclk_fall_sel = 1'b0; sclk = 1'b0; idle(8);
        send_sync(9'h0C3, 1'b0); compare_now("R4"); do_pop();
        sclk_fall_sel = 1'b1; sclk = 1'b1; idle(8);
        send_sync(9'h05A, 1'b0); compare_now("R4"); do_pop();
        par_en = 1'b1;
        send_sync(9'h01E, 1'b1); compare_now("R4"); do_pop();
        par_en = 1'b0;
        sync_mode = 1'b0; sclk_fall_sel = 1'b0; sclk = 1'b0; idle(8);

        // R8 and R10: ordering and overrun
        cur_req = "R10";
        send_async(9'h011, 1'b0, 1'b1);
        send_async(9'h022, 1'b0, 1'b1);
        send_async(9'h033, 1'b0, 1'b1);
        compare_now("R10");
        cur_req = "R8";
        do_pop(); compare_now("R8");
        do_pop(); compare_now("R8");

        // R12: pop on empty queue
        cur_req = "R12";
        do_pop(); idle(2); compare_now("R12");
        send_async(9'h044, 1'b0, 1'b1); compare_now("R12"); do_pop();

        // R11: flush and abort
        cur_req = "R11";
        send_async(9'h055, 1'b0, 1'b1);
        send_async(9'h066, 1'b0, 1'b1);
        flush_all();
        rxd = 1'b0; idle(96);
        rx_en = 1'b0; idle(4);
        rxd = 1'b1; idle(2);
        rx_en = 1'b1; idle(400);
        compare_now("R11");
        send_async(9'h077, 1'b0, 1'b1); compare_now("R11"); do_pop();

        idle(4);
        cmp_en = 1'b0;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: got no completion, exp finish before timeout");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule